// File: doc/BRIEF.md
# I2C Interrupt Status Flag Register

This block holds the eight status flags of an I2C controller and turns them into a single interrupt request. A separate shift and sequencing engine reports what happens on the bus through single-cycle strobes and level signals. These cover a byte taken for transmission, a byte fully received, an address hit, the first address byte with its direction bit and general-call result, bit samples used for arbitration, stop or repeated-start detection, and a missing acknowledge. The engine also reports whether it is currently shifting in a data byte or shifting out an address.

A CPU reaches the block through a small strobe bus. A read of the status address returns the flag byte one cycle later, and the read clears the event flags that are cleared by reading. Reads and writes of the data address are watched only for their side effects: a write marks the transmit holding register as full, and a read empties the receive indication. Deasserting the controller enable clears every flag.

Top module: `i2c_irq_status`

## Requirements
- R1: The status byte is {TXE[7], RXF[6], AHIT[5], GCALL[4], DIR[3], ALOST[2], STOPD[1], NACKD[0]}. After reset with the enable low, a status read returns 0x00 and `irq` is 0.
- R2: TXE (bit 7) is 1 exactly when the enable is high and no byte is pending. A CPU write to the data address makes a byte pending. `eng_tx_load` empties it. If both occur in one cycle, the write wins.
- R3: The TXE interrupt request is suppressed while `eng_shift_rx` is high, and while `eng_shift_addr` is high with DIR (bit 3) set.
- R4: RXF (bit 6) sets on `eng_rx_done` while enabled and clears on a CPU read of the data address.
- R5: AHIT (bit 5) sets on `eng_addr_hit` while enabled in slave mode (`master_mode`=0) and clears on a status read.
- R6: ALOST (bit 2) sets while enabled in master mode when `eng_bit_sample` sees `eng_sda_drive_hi`=1 and `eng_sda_line`=0. It clears on a status read.
- R7: DIR and GCALL change only on `eng_addr_first`. On that strobe, DIR takes `eng_dir_bit`, and GCALL takes `eng_gen_call` in slave mode or 0 in master mode.
- R8: STOPD (bit 1) sets on `eng_stop_seen` and NACKD (bit 0) sets on `eng_nack`, both only while enabled. Both clear on a status read.
- R9: When a set event and its clear fall in the same cycle, the flag ends up set. A status read returns the flags as they stood before that clock edge.
- R10: `cpu_rdata` updates one clock after a read strobe. It shows the status byte for the status address and 0x00 for any other address, and it holds between reads.
- R11: CPU writes to the status address change no flag.
- R12: A low enable clears all flags and the pending byte at the next edge. TXE reads 0 while the enable is low.
- R13: `irq` is the OR of the qualified TXE request with RXF, AHIT, ALOST, STOPD and NACKD. GCALL and DIR never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Controller enable |
| master_mode | input | 1 | 1 = master, 0 = slave |
| cpu_addr | input | ADDR_W | CPU register address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | Registered read data |
| eng_tx_load | input | 1 | Engine took the pending transmit byte |
| eng_rx_done | input | 1 | Engine finished receiving a byte |
| eng_addr_hit | input | 1 | Slave address matched |
| eng_addr_first | input | 1 | First address byte of a transaction done |
| eng_gen_call | input | 1 | First address byte was a general call |
| eng_dir_bit | input | 1 | Direction bit of the first address byte |
| eng_bit_sample | input | 1 | SDA sample strobe |
| eng_sda_drive_hi | input | 1 | Controller is releasing SDA high |
| eng_sda_line | input | 1 | Sampled SDA level |
| eng_stop_seen | input | 1 | Stop or repeated start detected |
| eng_nack | input | 1 | Missing acknowledge detected |
| eng_shift_rx | input | 1 | Engine is shifting in a data byte |
| eng_shift_addr | input | 1 | Engine is shifting out an address |
| irq | output | 1 | Interrupt request |

## Verification
Every flag changes at the clock edge that samples its strobe. Because `irq` is combinational from those flags and the shift-phase levels, it is due in the same cycle. A status value is due on `cpu_rdata` after the edge that samples the read strobe, and it carries the flags from before that edge.

The bench drives all inputs on the falling edge and updates its model on the rising edge. It compares `irq` and `cpu_rdata` at the following falling edge. Directed checks read the status byte with an explicit read cycle and compare it against literal values taken from the bit layout.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

  localparam int STAT_W = 8;

  // Flag byte, MSB first; the bit order is what software decodes.
  typedef struct packed {
    logic txe;
    logic rxf;
    logic ahit;
    logic gcall;
    logic dir;
    logic alost;
    logic stopd;
    logic nackd;
  } stat_t;

  // Indices of the event flags kept in the flag-cell array.
  localparam int EV_RXF   = 0;
  localparam int EV_AHIT  = 1;
  localparam int EV_ALOST = 2;
  localparam int EV_STOPD = 3;
  localparam int EV_NACKD = 4;
  localparam int EV_NUM   = 5;

endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/i2c_flag_cell.sv
// One event flag: cleared while disabled, set priority over clear.
module i2c_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag_q
);

  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (!enable) begin
      flag_d = 1'b0;
    end else if (set_ev) begin
      flag_d = 1'b1;
    end else if (clr_ev) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/i2c_stat_bus.sv
// CPU strobe decode and registered read-data port.
module i2c_stat_bus #(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 1,
  parameter int DATA_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        status,
  output logic              data_wr,
  output logic              data_rd,
  output logic              stat_rd,
  output logic [7:0]        cpu_rdata
);

  localparam logic [ADDR_W-1:0] STAT_A = STAT_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] DATA_A = DATA_ADDR[ADDR_W-1:0];

  logic       hit_stat;
  logic       hit_data;
  logic       rdata_en;
  logic [7:0] rdata_d;

  always_comb begin
    hit_stat = (cpu_addr == STAT_A);
    hit_data = (cpu_addr == DATA_A);
    data_wr  = cpu_wr && hit_data;
    data_rd  = cpu_rd && hit_data;
    stat_rd  = cpu_rd && hit_stat;
    rdata_en = cpu_rd;
    rdata_d  = stat_rd ? status : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdata <= 8'h00;
    end else if (rdata_en) begin
      cpu_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/i2c_irq_qual.sv
// Interrupt qualification: TXE request masked during certain shift phases.
module i2c_irq_qual #(
  parameter int EV_N = 5
) (
  input  logic            txe,
  input  logic            dir,
  input  logic            shift_rx,
  input  logic            shift_addr,
  input  logic [EV_N-1:0] ev_flags,
  output logic            irq
);

  logic txe_mask;
  logic txe_req;

  always_comb begin
    txe_mask = shift_rx || (shift_addr && dir);
    txe_req  = txe && !txe_mask;
    irq      = txe_req || (|ev_flags);
  end

endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_stat_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 1,
  parameter int DATA_ADDR = 0,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_en,
  input  logic              master_mode,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [7:0]        cpu_rdata,
  input  logic              eng_tx_load,
  input  logic              eng_rx_done,
  input  logic              eng_addr_hit,
  input  logic              eng_addr_first,
  input  logic              eng_gen_call,
  input  logic              eng_dir_bit,
  input  logic              eng_bit_sample,
  input  logic              eng_sda_drive_hi,
  input  logic              eng_sda_line,
  input  logic              eng_stop_seen,
  input  logic              eng_nack,
  input  logic              eng_shift_rx,
  input  logic              eng_shift_addr,
  output logic              irq
);

  logic              rst_ln;
  logic              data_wr;
  logic              data_rd;
  logic              stat_rd;
  logic              pend_q;
  logic              pend_d;
  logic [1:0]        hdr_q;
  logic [1:0]        hdr_d;
  logic [EV_NUM-1:0] ev_set;
  logic [EV_NUM-1:0] ev_clr;
  logic [EV_NUM-1:0] ev_q;
  stat_t             stat_s;
  logic [7:0]        stat_w;

  i2c_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ln)
  );

  i2c_stat_bus #(
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR),
    .DATA_ADDR (DATA_ADDR)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_ln),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .status    (stat_w),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .stat_rd   (stat_rd),
    .cpu_rdata (cpu_rdata)
  );

  // Transmit holding state: a CPU write beats an engine load.
  always_comb begin
    pend_d = pend_q;
    if (!ctl_en) begin
      pend_d = 1'b0;
    end else if (data_wr) begin
      pend_d = 1'b1;
    end else if (eng_tx_load) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  // Transaction header bits: {general call, direction}.
  always_comb begin
    hdr_d = hdr_q;
    if (!ctl_en) begin
      hdr_d = 2'b00;
    end else if (eng_addr_first) begin
      hdr_d = {(!master_mode && eng_gen_call), eng_dir_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      hdr_q <= 2'b00;
    end else begin
      hdr_q <= hdr_d;
    end
  end

  // Event flag set and clear terms.
  always_comb begin
    ev_set           = '0;
    ev_clr           = '0;
    ev_set[EV_RXF]   = eng_rx_done;
    ev_clr[EV_RXF]   = data_rd;
    ev_set[EV_AHIT]  = !master_mode && eng_addr_hit;
    ev_clr[EV_AHIT]  = stat_rd;
    ev_set[EV_ALOST] = master_mode && eng_bit_sample && eng_sda_drive_hi && !eng_sda_line;
    ev_clr[EV_ALOST] = stat_rd;
    ev_set[EV_STOPD] = eng_stop_seen;
    ev_clr[EV_STOPD] = stat_rd;
    ev_set[EV_NACKD] = eng_nack;
    ev_clr[EV_NACKD] = stat_rd;
  end

  for (genvar g = 0; g < EV_NUM; g++) begin : g_ev
    i2c_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_ln),
      .enable (ctl_en),
      .set_ev (ev_set[g]),
      .clr_ev (ev_clr[g]),
      .flag_q (ev_q[g])
    );
  end

  always_comb begin
    stat_s.txe   = ctl_en && !pend_q;
    stat_s.rxf   = ev_q[EV_RXF];
    stat_s.ahit  = ev_q[EV_AHIT];
    stat_s.gcall = hdr_q[1];
    stat_s.dir   = hdr_q[0];
    stat_s.alost = ev_q[EV_ALOST];
    stat_s.stopd = ev_q[EV_STOPD];
    stat_s.nackd = ev_q[EV_NACKD];
    stat_w       = stat_s;
  end

  i2c_irq_qual #(.EV_N(EV_NUM)) u_irq (
    .txe        (stat_s.txe),
    .dir        (stat_s.dir),
    .shift_rx   (eng_shift_rx),
    .shift_addr (eng_shift_addr),
    .ev_flags   (ev_q),
    .irq        (irq)
  );

endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       master,
  input logic       rx_done,
  input logic       addr_hit,
  input logic       addr_first,
  input logic       stat_rd,
  input logic       shift_rx,
  input logic [7:0] status,
  input logic       irq
);

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (status[6:0] == 7'd0)); // R12

  AST_RXF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_done) |=> status[6]); // R4

  AST_AHIT_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(en && !master && addr_hit)) |=> !status[5]); // R5

  AST_ALOST_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(master)); // R6

  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !addr_first) |=> $stable(status[4:3])); // R7

  AST_TXE_MASK_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_rx && !status[6] && !status[5] && (status[2:0] == 3'd0)) |-> !irq); // R3

endmodule

bind i2c_irq_status i2c_irq_status_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_ln),
  .en         (ctl_en),
  .master     (master_mode),
  .rx_done    (eng_rx_done),
  .addr_hit   (eng_addr_hit),
  .addr_first (eng_addr_first),
  .stat_rd    (stat_rd),
  .shift_rx   (eng_shift_rx),
  .status     (stat_w),
  .irq        (irq)
);

// File: tb/test_i2c_irq_status.sv
module test_i2c_irq_status;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam logic [ADDR_W-1:0] STAT_A = 4'd1;
  localparam logic [ADDR_W-1:0] DATA_A = 4'd0;
  localparam logic [ADDR_W-1:0] OTHER_A = 4'd7;

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_en, master_mode, cpu_wr, cpu_rd;
  logic [ADDR_W-1:0] cpu_addr;
  logic [7:0] cpu_rdata;
  logic eng_tx_load, eng_rx_done, eng_addr_hit, eng_addr_first, eng_gen_call;
  logic eng_dir_bit, eng_bit_sample, eng_sda_drive_hi, eng_sda_line;
  logic eng_stop_seen, eng_nack, eng_shift_rx, eng_shift_addr;
  logic irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // Bench model state
  logic m_pend, m_rxf, m_ahit, m_gcall, m_dir, m_alost, m_stopd, m_nackd;
  logic [7:0] m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_status #(.ADDR_W(ADDR_W), .STAT_ADDR(1), .DATA_ADDR(0)) i_i2c_irq_status (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .master_mode(master_mode),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .eng_tx_load(eng_tx_load), .eng_rx_done(eng_rx_done), .eng_addr_hit(eng_addr_hit),
    .eng_addr_first(eng_addr_first), .eng_gen_call(eng_gen_call), .eng_dir_bit(eng_dir_bit),
    .eng_bit_sample(eng_bit_sample), .eng_sda_drive_hi(eng_sda_drive_hi),
    .eng_sda_line(eng_sda_line), .eng_stop_seen(eng_stop_seen), .eng_nack(eng_nack),
    .eng_shift_rx(eng_shift_rx), .eng_shift_addr(eng_shift_addr), .irq(irq)
  );

  function automatic logic [7:0] exp_status();
    return {ctl_en && !m_pend, m_rxf, m_ahit, m_gcall, m_dir, m_alost, m_stopd, m_nackd};
  endfunction

  function automatic logic exp_irq();
    logic txe_req;
    txe_req = ctl_en && !m_pend && !(eng_shift_rx || (eng_shift_addr && m_dir));
    return txe_req || m_rxf || m_ahit || m_alost || m_stopd || m_nackd;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [7:0] s_old;
    logic d_wr, d_rd, s_rd;
    s_old = exp_status();
    d_wr = cpu_wr && (cpu_addr == DATA_A);
    d_rd = cpu_rd && (cpu_addr == DATA_A);
    s_rd = cpu_rd && (cpu_addr == STAT_A);
    if (cpu_rd) m_rdata = s_rd ? s_old : 8'h00;
    if (!ctl_en) begin
      {m_pend, m_rxf, m_ahit, m_gcall, m_dir, m_alost, m_stopd, m_nackd} = '0;
    end else begin
      if (d_wr) m_pend = 1'b1; else if (eng_tx_load) m_pend = 1'b0;
      if (eng_rx_done) m_rxf = 1'b1; else if (d_rd) m_rxf = 1'b0;
      if (!master_mode && eng_addr_hit) m_ahit = 1'b1; else if (s_rd) m_ahit = 1'b0;
      if (master_mode && eng_bit_sample && eng_sda_drive_hi && !eng_sda_line) m_alost = 1'b1;
      else if (s_rd) m_alost = 1'b0;
      if (eng_stop_seen) m_stopd = 1'b1; else if (s_rd) m_stopd = 1'b0;
      if (eng_nack) m_nackd = 1'b1; else if (s_rd) m_nackd = 1'b0;
      if (eng_addr_first) begin
        m_gcall = !master_mode && eng_gen_call;
        m_dir   = eng_dir_bit;
      end
    end
  endtask

  // One clock: model updates on the rising edge, outputs compared at the falling edge.
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R13 irq", {7'd0, irq}, {7'd0, exp_irq()});
    check("R10 rdata", cpu_rdata, m_rdata);
  endtask

  task automatic idle_pulses();
    cpu_wr = 0; cpu_rd = 0; cpu_addr = '0;
    eng_tx_load = 0; eng_rx_done = 0; eng_addr_hit = 0; eng_addr_first = 0;
    eng_gen_call = 0; eng_dir_bit = 0; eng_bit_sample = 0; eng_sda_drive_hi = 0;
    eng_sda_line = 1; eng_stop_seen = 0; eng_nack = 0;
  endtask

  task automatic read_status(output logic [7:0] v);
    cpu_rd = 1; cpu_addr = STAT_A;
    tick();
    v = cpu_rdata;
    idle_pulses();
  endtask

  task automatic cpu_access(input logic wr, input logic [ADDR_W-1:0] a);
    cpu_wr = wr; cpu_rd = !wr; cpu_addr = a;
    tick();
    idle_pulses();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int unsigned seed_ret;
    seed_ret = $urandom(32'h1C5A7);
    rst_n = 0; ctl_en = 0; master_mode = 0; eng_shift_rx = 0; eng_shift_addr = 0;
    idle_pulses();
    {m_pend, m_rxf, m_ahit, m_gcall, m_dir, m_alost, m_stopd, m_nackd} = '0;
    m_rdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) tick();

    // R1: reset state
    read_status(v); check("R1 reset status", v, 8'h00);
    check("R1 reset irq", {7'd0, irq}, 8'h00);

    // R2 / R13: enabled and empty
    ctl_en = 1; tick();
    check("R13 txe irq", {7'd0, irq}, 8'h01);
    read_status(v); check("R2 txe when empty", v, 8'h80);
    cpu_access(1'b1, DATA_A);
    read_status(v); check("R2 write clears txe", v, 8'h00);
    eng_tx_load = 1; tick(); idle_pulses();
    read_status(v); check("R2 load sets txe", v, 8'h80);
    cpu_wr = 1; cpu_addr = DATA_A; eng_tx_load = 1; tick(); idle_pulses();
    read_status(v); check("R2 write wins over load", v, 8'h00);
    eng_tx_load = 1; tick(); idle_pulses();

    // R3: masking of txe request
    eng_shift_rx = 1; tick();
    check("R3 mask shift_rx", {7'd0, irq}, 8'h00);
    eng_shift_rx = 0; eng_shift_addr = 1; tick();
    check("R3 addr shift dir0 unmasked", {7'd0, irq}, 8'h01);
    eng_addr_first = 1; eng_dir_bit = 1; tick(); idle_pulses();
    tick();
    check("R3 addr shift dir1 masked", {7'd0, irq}, 8'h00);
    eng_shift_addr = 0;
    read_status(v); check("R7 dir from first byte", v, 8'h88);

    // R7: general call, master override, hold without strobe
    eng_addr_first = 1; eng_gen_call = 1; eng_dir_bit = 0; tick(); idle_pulses();
    read_status(v); check("R7 gcall slave", v, 8'h90);
    eng_gen_call = 1; eng_dir_bit = 1; tick(); idle_pulses();
    read_status(v); check("R7 hold without strobe", v, 8'h90);
    master_mode = 1; eng_addr_first = 1; eng_gen_call = 1; tick(); idle_pulses();
    read_status(v); check("R7 gcall 0 in master", v, 8'h80);
    master_mode = 0;

    // R4 / R9
    eng_rx_done = 1; tick(); idle_pulses();
    read_status(v); check("R4 rxf set", v, 8'hC0);
    cpu_access(1'b0, DATA_A);
    check("R10 other address reads zero", cpu_rdata, 8'h00);
    read_status(v); check("R4 data read clears rxf", v, 8'h80);
    eng_rx_done = 1; cpu_rd = 1; cpu_addr = DATA_A; tick(); idle_pulses();
    read_status(v); check("R9 rxf set wins", v, 8'hC0);
    cpu_access(1'b0, DATA_A);

    // R5
    eng_addr_hit = 1; tick(); idle_pulses();
    read_status(v); check("R5 ahit set", v, 8'hA0);
    read_status(v); check("R5 ahit read clear", v, 8'h80);
    master_mode = 1; eng_addr_hit = 1; tick(); idle_pulses();
    read_status(v); check("R5 no ahit in master", v, 8'h80);

    // R6
    eng_bit_sample = 1; eng_sda_drive_hi = 1; eng_sda_line = 0; tick(); idle_pulses();
    read_status(v); check("R6 alost set", v, 8'h84);
    read_status(v); check("R6 alost read clear", v, 8'h80);
    eng_bit_sample = 1; eng_sda_drive_hi = 1; eng_sda_line = 1; tick(); idle_pulses();
    read_status(v); check("R6 no loss line high", v, 8'h80);
    master_mode = 0;
    eng_bit_sample = 1; eng_sda_drive_hi = 1; eng_sda_line = 0; tick(); idle_pulses();
    read_status(v); check("R6 no loss in slave", v, 8'h80);

    // R8
    eng_stop_seen = 1; eng_nack = 1; tick(); idle_pulses();
    read_status(v); check("R8 stopd nackd set", v, 8'h83);
    read_status(v); check("R8 read clear", v, 8'h80);

    // R9: set during status read
    eng_addr_hit = 1; cpu_rd = 1; cpu_addr = STAT_A; tick(); v = cpu_rdata; idle_pulses();
    check("R9 read returns pre-edge value", v, 8'h80);
    read_status(v); check("R9 set wins over read clear", v, 8'hA0);

    // R11
    eng_nack = 1; tick(); idle_pulses();
    cpu_access(1'b1, STAT_A);
    read_status(v); check("R11 status write ignored", v, 8'h81);

    // R12
    eng_rx_done = 1; eng_addr_first = 1; eng_dir_bit = 1; tick(); idle_pulses();
    cpu_access(1'b1, DATA_A);
    ctl_en = 0; tick();
    check("R12 irq off when disabled", {7'd0, irq}, 8'h00);
    read_status(v); check("R12 disabled clears all", v, 8'h00);
    ctl_en = 1; tick();
    read_status(v); check("R12 pending cleared", v, 8'h80);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned op;
      ctl_en = ($urandom % 40) != 0;
      if (($urandom % 30) == 0) master_mode = ~master_mode;
      eng_shift_rx = ($urandom % 4) == 0;
      eng_shift_addr = ($urandom % 4) == 0;
      eng_tx_load = ($urandom % 6) == 0;
      eng_rx_done = ($urandom % 8) == 0;
      eng_addr_hit = ($urandom % 10) == 0;
      eng_addr_first = ($urandom % 8) == 0;
      eng_gen_call = $urandom % 2;
      eng_dir_bit = $urandom % 2;
      eng_bit_sample = $urandom % 2;
      eng_sda_drive_hi = $urandom % 2;
      eng_sda_line = $urandom % 2;
      eng_stop_seen = ($urandom % 12) == 0;
      eng_nack = ($urandom % 12) == 0;
      op = $urandom % 16;
      cpu_wr = 0; cpu_rd = 0; cpu_addr = '0;
      case (op)
        0, 1, 2: begin cpu_rd = 1; cpu_addr = STAT_A; end
        3, 4:    begin cpu_rd = 1; cpu_addr = DATA_A; end
        5, 6:    begin cpu_wr = 1; cpu_addr = DATA_A; end
        7:       begin cpu_wr = 1; cpu_addr = STAT_A; end
        8:       begin cpu_rd = 1; cpu_addr = OTHER_A; end
        default: ;
      endcase
      tick();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule